// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins, reached over a plain single-cycle 32-bit register bus with a byte address, a write strobe, write data and combinational read data. Each pin has an output latch and a direction bit. The pin inputs pass through a two-flop synchroniser before software sees them or they are tested for interrupts.

Every pin is also an interrupt source. Three per-pin configuration bits choose its trigger: edge or level, which polarity, and an optional any-edge mode. Each source is a small two-state machine. In state `SRC_IDLE` a trigger takes the transition FIRE into `SRC_LATCHED`. In `SRC_LATCHED`, a write-one-to-clear with no trigger present takes the transition ACK back to `SRC_IDLE`. A trigger in that same cycle takes the transition HOLD, which keeps the source latched. An enable mask gates the latched sources into pending bits, and the OR of the pending bits drives one interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the enable (0x08), edge select (0x18), any-edge (0x24), latched status (0x0C) and output latch (0x00, output side) are all zero. The direction (0x04) and polarity (0x1C) registers are all ones. `irq_out` is low.
- R2: A write to offset 0x00 sets the output latch, and `pin_out` follows it on the next cycle. A read of 0x00 returns, for each bit, the synchronised `pin_in` level where the direction bit is 1 (input) and the output latch where it is 0 (output). `pin_is_input` mirrors the direction register.
- R3: With the edge-select bit at 0 (level mode), the status bit at 0x0C sets while the synchronised pin equals the polarity bit (1 = high, 0 = low). A clear written while that level is still present leaves the bit set.
- R4: With edge select at 1 and any-edge at 0, a rising edge sets the status bit when polarity is 1, and a falling edge sets it when polarity is 0. A steady pin sets nothing.
- R5: With edge select at 1 and any-edge at 1, both rising and falling edges set the status bit. In level mode the any-edge bit has no effect.
- R6: Writing a 1 to a bit of the clear register (0x14) returns an inactive latched source to 0. Writing 0 bits changes nothing. The clear register reads as 0.
- R7: Offset 0x10 reads the status bits AND the enable mask. Offset 0x0C reads the status bits unmasked.
- R8: `irq_out` is the OR of the pending bits. It is low whenever the enable mask is zero.
- R9: Offset 0x20 reads the constant 3, and writes to it are ignored. Unmapped offsets, and addresses whose two low bits are not zero, read 0.
- R10: The direction, enable, edge select, polarity and any-edge registers read back the value last written to them.
- R11: A pin change becomes visible in the status register within four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | PINS | Asynchronous pin levels |
| pin_out | output | PINS | Output latch value |
| pin_is_input | output | PINS | Direction per pin, 1 = input |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is a level-mode source that receives a clear while its level is still present. The HOLD transition must win there, and a later clear after the level drops must then succeed. The random stimulus reaches this state every iteration. It first settles the pins to one pattern and clears everything, which leaves only the level-active sources latched. It then moves to a second pattern and checks the status against the union of both patterns' active levels. A partial random clear follows, so edge and level sources, enabled and masked, are all cleared in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 6;
    localparam int WORD_LSB   = 2;
    localparam int WORD_IDX_W = ADDR_W - WORD_LSB;

    // Word index of each register (byte offset divided by four).
    typedef enum logic [WORD_IDX_W-1:0] {
        RG_LEVEL = 4'h0,
        RG_DIR   = 4'h1,
        RG_IEN   = 4'h2,
        RG_STAT  = 4'h3,
        RG_PEND  = 4'h4,
        RG_CLR   = 4'h5,
        RG_TRIG  = 4'h6,
        RG_POL   = 4'h7,
        RG_VER   = 4'h8,
        RG_DUAL  = 4'h9
    } reg_sel_e;

    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_LATCHED = 1'b1
    } src_state_e;

    localparam logic [BUS_W-1:0] HW_VERSION = 32'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] now_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end
endmodule

// File: rtl/gpio_irq_src.sv
module gpio_irq_src
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic lvl_prev,
    input  logic edge_mode,
    input  logic pol_high,
    input  logic dual_edge,
    input  logic clr,
    output logic latched
);
    src_state_e state_q, state_d;
    logic rise, fall, trig;

    always_comb begin
        rise = lvl_now & ~lvl_prev;
        fall = ~lvl_now & lvl_prev;
        if (edge_mode)
            trig = dual_edge ? (rise | fall) : (pol_high ? rise : fall);
        else
            trig = (lvl_now == pol_high);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE:    if (trig) state_d = SRC_LATCHED;          // FIRE
            SRC_LATCHED: if (clr && !trig) state_d = SRC_IDLE;     // ACK, else HOLD
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        latched = (state_q == SRC_LATCHED);
    end

    assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && (lvl_now == pol_high)) |=> latched);

    assert_edge_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && (lvl_now == lvl_prev) && !latched) |=> !latched);

    assert_clear_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && clr && edge_mode && (lvl_now == lvl_prev)) |=> !latched);
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [PINS-1:0]  pin_now,
    input  logic [PINS-1:0]  status,
    output logic [PINS-1:0]  out_q,
    output logic [PINS-1:0]  dir_q,
    output logic [PINS-1:0]  ien_q,
    output logic [PINS-1:0]  trig_q,
    output logic [PINS-1:0]  pol_q,
    output logic [PINS-1:0]  dual_q,
    output logic [PINS-1:0]  clr_mask
);
    logic             hit;
    reg_sel_e         sel;
    logic [PINS-1:0]  wval;

    function automatic logic [BUS_W-1:0] widen(input logic [PINS-1:0] v);
        logic [BUS_W-1:0] r;
        r = '0;
        r[PINS-1:0] = v;
        return r;
    endfunction

    always_comb begin
        hit  = (bus_addr[WORD_LSB-1:0] == '0);
        sel  = reg_sel_e'(bus_addr[ADDR_W-1:WORD_LSB]);
        wval = bus_wdata[PINS-1:0];
        clr_mask = (bus_we && hit && sel == RG_CLR) ? wval : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '1;
            ien_q  <= '0;
            trig_q <= '0;
            pol_q  <= '1;
            dual_q <= '0;
        end else if (bus_we && hit) begin
            case (sel)
                RG_LEVEL: out_q  <= wval;
                RG_DIR:   dir_q  <= wval;
                RG_IEN:   ien_q  <= wval;
                RG_TRIG:  trig_q <= wval;
                RG_POL:   pol_q  <= wval;
                RG_DUAL:  dual_q <= wval;
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (sel)
                RG_LEVEL: bus_rdata = widen((pin_now & dir_q) | (out_q & ~dir_q));
                RG_DIR:   bus_rdata = widen(dir_q);
                RG_IEN:   bus_rdata = widen(ien_q);
                RG_STAT:  bus_rdata = widen(status);
                RG_PEND:  bus_rdata = widen(status & ien_q);
                RG_TRIG:  bus_rdata = widen(trig_q);
                RG_POL:   bus_rdata = widen(pol_q);
                RG_VER:   bus_rdata = HW_VERSION;
                RG_DUAL:  bus_rdata = widen(dual_q);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_is_input,
    output logic              irq_out
);
    logic [PINS-1:0] lvl_now, lvl_prev, status;
    logic [PINS-1:0] out_q, dir_q, ien_q, trig_q, pol_q, dual_q, clr_mask;

    gpio_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .now_q  (lvl_now),
        .prev_q (lvl_prev)
    );

    gpio_regfile #(.PINS(PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_now   (lvl_now),
        .status    (status),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .ien_q     (ien_q),
        .trig_q    (trig_q),
        .pol_q     (pol_q),
        .dual_q    (dual_q),
        .clr_mask  (clr_mask)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_src
        gpio_irq_src u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_now   (lvl_now[i]),
            .lvl_prev  (lvl_prev[i]),
            .edge_mode (trig_q[i]),
            .pol_high  (pol_q[i]),
            .dual_edge (dual_q[i]),
            .clr       (clr_mask[i]),
            .latched   (status[i])
        );
    end

    always_comb begin
        pin_out      = out_q;
        pin_is_input = dir_q;
        irq_out      = |(status & ien_q);
    end

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_out);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($countones(status & ien_q) != 0));
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int PINS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_is_input;
    logic        irq_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.PINS(PINS)) i_gpio_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_is_input (pin_is_input),
        .irq_out      (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (5) @(negedge clk);
    endtask

    // Status expected after settling on pattern a, clearing all, then moving to b.
    function automatic logic [31:0] exp_status(input logic [31:0] trg, input logic [31:0] pol,
                                               input logic [31:0] dual, input logic [31:0] a,
                                               input logic [31:0] b);
        logic [31:0] lvl, rise, fall, edg;
        lvl  = ~trg & (~(a ^ pol) | ~(b ^ pol));
        rise = ~a & b;
        fall = a & ~b;
        edg  = trg & ((dual & (rise | fall)) | (~dual & ((pol & rise) | (~pol & fall))));
        return lvl | edg;
    endfunction

    initial begin
        logic [31:0] rd, v, dirv, outv, trg, pol, dual, pa, pb, ien, st, m;
        v = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1)
        bus_rd(6'h04, rd); check("R1 dir", rd, 32'hFFFF_FFFF);
        bus_rd(6'h08, rd); check("R1 ien", rd, 32'h0);
        bus_rd(6'h18, rd); check("R1 trig", rd, 32'h0);
        bus_rd(6'h1C, rd); check("R1 pol", rd, 32'hFFFF_FFFF);
        bus_rd(6'h24, rd); check("R1 dual", rd, 32'h0);
        bus_rd(6'h0C, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);

        // Read-back of configuration registers (R10), clear reads zero (R6)
        for (int k = 0; k < 4; k++) begin
            v = $urandom; bus_wr(6'h04, v); bus_rd(6'h04, rd); check("R10 dir", rd, v);
            v = $urandom; bus_wr(6'h08, v); bus_rd(6'h08, rd); check("R10 ien", rd, v);
            v = $urandom; bus_wr(6'h18, v); bus_rd(6'h18, rd); check("R10 trig", rd, v);
            v = $urandom; bus_wr(6'h1C, v); bus_rd(6'h1C, rd); check("R10 pol", rd, v);
            v = $urandom; bus_wr(6'h24, v); bus_rd(6'h24, rd); check("R10 dual", rd, v);
        end
        bus_rd(6'h14, rd); check("R6 clr reads 0", rd, 32'h0);

        // Version and unmapped (R9)
        bus_rd(6'h20, rd); check("R9 version", rd, 32'd3);
        bus_wr(6'h20, 32'hDEAD_BEEF);
        bus_rd(6'h20, rd); check("R9 version after write", rd, 32'd3);
        bus_rd(6'h28, rd); check("R9 unmapped", rd, 32'h0);
        bus_rd(6'h05, rd); check("R9 misaligned", rd, 32'h0);

        // Value and direction (R2)
        bus_wr(6'h08, 32'h0);
        dirv = 32'h0000_FFFF; outv = 32'hA5A5_5A5A;
        bus_wr(6'h04, dirv);
        bus_wr(6'h00, outv);
        check("R2 pin_out", pin_out, outv);
        check("R2 pin_is_input", pin_is_input, dirv);
        drive_pins(32'h1234_ABCD);
        bus_rd(6'h00, rd); check("R2 value read", rd, (32'h1234_ABCD & dirv) | (outv & ~dirv));

        // Level hold against clear (R3)
        bus_wr(6'h18, 32'h0); bus_wr(6'h1C, 32'hFFFF_FFFF); bus_wr(6'h24, 32'h0);
        drive_pins(32'h0000_0001);
        bus_wr(6'h14, 32'hFFFF_FFFF);
        bus_rd(6'h0C, rd); check("R3 level held", rd, 32'h0000_0001);
        drive_pins(32'h0);
        bus_wr(6'h14, 32'hFFFF_FFFF);
        bus_rd(6'h0C, rd); check("R3 level released", rd, 32'h0);

        // Falling edge with latency bound (R4, R11)
        bus_wr(6'h18, 32'hFFFF_FFFF); bus_wr(6'h1C, 32'h0);
        drive_pins(32'h0000_00F0);
        bus_wr(6'h14, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = 32'h0;
        repeat (4) @(negedge clk);
        bus_addr = 6'h0C; #1 check("R11 status within 4 cycles", bus_rdata, 32'h0000_00F0);

        // Masking (R8)
        check("R8 masked irq", {31'b0, irq_out}, 32'h0);
        bus_wr(6'h08, 32'h0000_0010);
        check("R8 irq high", {31'b0, irq_out}, 32'h1);
        bus_wr(6'h14, 32'h0000_0010);
        check("R8 irq low after clear", {31'b0, irq_out}, 32'h0);

        // Random mixed triggers (R3, R4, R5, R6, R7, R8)
        for (int it = 0; it < 40; it++) begin
            trg = $urandom; pol = $urandom; dual = $urandom; ien = $urandom;
            pa = $urandom; pb = $urandom;
            if (it % 8 == 0) pb = pa;
            bus_wr(6'h08, 32'h0);
            bus_wr(6'h18, trg); bus_wr(6'h1C, pol); bus_wr(6'h24, dual);
            drive_pins(pa);
            bus_wr(6'h14, 32'hFFFF_FFFF);
            drive_pins(pb);
            bus_wr(6'h08, ien);
            st = exp_status(trg, pol, dual, pa, pb);
            bus_rd(6'h0C, rd); check("R5 status (R3/R4 mix)", rd, st);
            bus_rd(6'h10, rd); check("R7 pending", rd, st & ien);
            check("R8 irq", {31'b0, irq_out}, {31'b0, |(st & ien)});
            bus_wr(6'h14, 32'h0);
            bus_rd(6'h0C, rd); check("R6 zero clear no effect", rd, st);
            m = $urandom;
            bus_wr(6'h14, m);
            bus_rd(6'h0C, rd);
            check("R6 partial clear", rd, (st & ~m) | (m & ~trg & ~(pb ^ pol)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: got hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule